// File: doc/BRIEF.md
# Trap Entry Status Stacker

This block holds the status word and the backup control registers of a small processor core. When the pipeline signals that a software trap instruction is executing, the block shifts the status fields and saved program counters one level deeper. It also produces the address from which the core fetches next. Everything a single trap changes is updated together on one clock edge.

Three copies of a three-bit status record are kept: current, backup and second backup. Each record holds a supervisor flag, an interrupt-enable flag and a condition flag. Two saved-PC levels sit beside them: the backup PC and the second backup PC.

Software reaches all four registers through a small move-to/move-from control port. The read side is combinational, so a read always returns the state as it stood before the current clock edge.

Top module: `trap_state_stack`

## Requirements
- R1: Register select 0 reads the status word with the current fields at supervisor bit 7, interrupt-enable bit 6 and condition bit 0. The backup fields sit at supervisor bit 15, interrupt-enable bit 14 and condition bit 8. Every other bit reads 0. A write with select 0 loads all six fields from the same bit positions.
- R2: Register select 1 reads and writes the second-backup status word, with supervisor at bit 7, interrupt-enable at bit 6 and condition at bit 0. Every other bit reads 0.
- R3: On a trap, the second-backup fields take the old backup fields.
- R4: On a trap, the backup fields take the old current fields. The current supervisor flag keeps its value, and current interrupt-enable and condition become 0. For example, status 0x00C1 becomes 0xC180 and status 0xC100 becomes 0x0000.
- R5: On a trap, the second backup PC (select 3) takes the old backup PC.
- R6: On a trap, the backup PC (select 2) takes the trap address plus 4.
- R7: While `trap_valid` is high, `vector_valid` is high and `vector_addr` equals 0x40 + 4 × `trap_num`. Trap number 2 gives 0x48.
- R8: All of a trap's updates land on the same rising edge. A read in the trap cycle returns the pre-trap value.
- R9: A register write in a cycle with `trap_valid` high is ignored, and the trap update is applied instead.
- R10: After reset, all status fields and both backup PCs read 0.
- R11: Both backup PC registers store their two least significant bits as 0 on every load, whether by write or by trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Move-to-control write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 second-backup status, 2 backup PC, 3 second backup PC |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| trap_valid | input | 1 | A trap instruction executes this cycle |
| trap_num | input | 4 | Trap number |
| trap_pc | input | 32 | Address of the trapping instruction |
| vector_valid | output | 1 | Redirect request |
| vector_addr | output | 32 | Next fetch address for the trap handler |

## Verification
The assertions assume `trap_valid` is a clean single-cycle or multi-cycle level that is sampled only at rising edges. They also assume `trap_pc` is stable whenever `trap_valid` is high. The bench meets both assumptions by driving every input on falling edges and holding it for a full cycle. It runs one trap per iteration over all 64 combinations of current and backup fields. Some of those traps coincide with a write, and all sixteen trap numbers are visited, with PC values whose low bits are nonzero so that the alignment rule is exercised.

// File: rtl/trap_stack_pkg.sv
package trap_stack_pkg;

   typedef struct packed {
      logic sup;
      logic ien;
      logic cnd;
   } stat_rec_t;

   typedef enum logic [1:0] {
      SEL_STAT  = 2'd0,
      SEL_STAT2 = 2'd1,
      SEL_SPC   = 2'd2,
      SEL_SPC2  = 2'd3
   } ctl_sel_e;

   localparam int STAT_LEVELS = 3;
   localparam int SUP_POS     = 7;
   localparam int IEN_POS     = 6;
   localparam int CND_POS     = 0;
   localparam int BAK_SHIFT   = 8;

   function automatic stat_rec_t rec_from_word(input logic [15:0] w, input int shift);
      stat_rec_t r;
      r.sup = w[SUP_POS + shift];
      r.ien = w[IEN_POS + shift];
      r.cnd = w[CND_POS + shift];
      return r;
   endfunction

   function automatic logic [15:0] word_from_rec(input stat_rec_t r, input int shift);
      logic [15:0] w;
      w = '0;
      w[SUP_POS + shift] = r.sup;
      w[IEN_POS + shift] = r.ien;
      w[CND_POS + shift] = r.cnd;
      return w;
   endfunction

endpackage

// File: rtl/tss_status_stack.sv
module tss_status_stack
   import trap_stack_pkg::*;
#(
   parameter int LEVELS = STAT_LEVELS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trap_take,
   input  logic [LEVELS-1:0]     wr_lvl,
   input  stat_rec_t [LEVELS-1:0] wr_rec,
   output stat_rec_t [LEVELS-1:0] lvl_q
);

   generate
      if (LEVELS < 2) begin : g_bad_levels
         $error("tss_status_stack: LEVELS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (trap_take) begin
         lvl_q[0].sup <= lvl_q[0].sup;
         lvl_q[0].ien <= 1'b0;
         lvl_q[0].cnd <= 1'b0;
         for (int i = 1; i < LEVELS; i++) begin
            lvl_q[i] <= lvl_q[i-1];
         end
      end else begin
         for (int i = 0; i < LEVELS; i++) begin
            if (wr_lvl[i]) lvl_q[i] <= wr_rec[i];
         end
      end
   end

   // R4: supervisor flag survives a trap, the other two are cleared
   a_r4_cur_fields: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |=> (lvl_q[0].sup == $past(lvl_q[0].sup)) && !lvl_q[0].ien && !lvl_q[0].cnd);

   // R4: the current record moves into the backup level
   a_r4_push_backup: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |=> lvl_q[1] == $past(lvl_q[0]));

   // R3: the deepest level takes the level above it
   a_r3_push_deep: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |=> lvl_q[LEVELS-1] == $past(lvl_q[LEVELS-2]));

endmodule

// File: rtl/tss_pc_stack.sv
module tss_pc_stack #(
   parameter int ADDR_W   = 32,
   parameter int DEPTH    = 2,
   parameter int RET_OFF  = 4,
   parameter int ALIGN_LG2 = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         trap_take,
   input  logic [ADDR_W-1:0]            trap_pc,
   input  logic [DEPTH-1:0]             wr_lvl,
   input  logic [ADDR_W-1:0]            wr_data,
   output logic [DEPTH-1:0][ADDR_W-1:0] pc_q
);

   localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-ALIGN_LG2){1'b1}}, {ALIGN_LG2{1'b0}}};
   localparam logic [ADDR_W-1:0] RET_INC    = ADDR_W'(RET_OFF);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tss_pc_stack: DEPTH must be at least 2");
      end
      if (ALIGN_LG2 < 1 || ALIGN_LG2 >= ADDR_W) begin : g_bad_align
         $error("tss_pc_stack: ALIGN_LG2 out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] ret_addr;
   assign ret_addr = (trap_pc + RET_INC) & ALIGN_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (trap_take) begin
         pc_q[0] <= ret_addr;
         for (int i = 1; i < DEPTH; i++) begin
            pc_q[i] <= pc_q[i-1];
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wr_lvl[i]) pc_q[i] <= wr_data & ALIGN_MASK;
         end
      end
   end

   // R5: older saved PC shifts down on a trap
   a_r5_pc_shift: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |=> pc_q[1] == $past(pc_q[0]));

   // R6: backup PC becomes trap address plus the return offset
   a_r6_ret_addr: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |=> pc_q[0][ADDR_W-1:ALIGN_LG2] == ($past(trap_pc) + RET_INC) >> ALIGN_LG2);

   // R11: stored PCs are always aligned
   a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q[0][ALIGN_LG2-1:0] == '0) && (pc_q[DEPTH-1][ALIGN_LG2-1:0] == '0));

endmodule

// File: rtl/tss_vector_gen.sv
module tss_vector_gen #(
   parameter int ADDR_W     = 32,
   parameter int NUM_W      = 4,
   parameter int VEC_BASE   = 'h40,
   parameter int STRIDE_LG2 = 2
) (
   input  logic [NUM_W-1:0]  num,
   output logic [ADDR_W-1:0] vec
);

   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);

   generate
      if (NUM_W + STRIDE_LG2 >= ADDR_W) begin : g_bad_width
         $error("tss_vector_gen: vector table does not fit the address width");
      end
   endgenerate

   assign vec = BASE + (ADDR_W'(num) << STRIDE_LG2);

endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack
   import trap_stack_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NUM_W      = 4,
   parameter int VEC_BASE   = 'h40,
   parameter int STRIDE_LG2 = 2,
   parameter int RET_OFF    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              trap_valid,
   input  logic [NUM_W-1:0]  trap_num,
   input  logic [ADDR_W-1:0] trap_pc,
   output logic              vector_valid,
   output logic [ADDR_W-1:0] vector_addr
);

   localparam int PC_DEPTH = 2;

   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("trap_state_stack: ADDR_W must be at least 16");
      end
   endgenerate

   logic wr_ok;
   assign wr_ok = reg_wr_en && !trap_valid;

   // status stack write paths
   logic      [STAT_LEVELS-1:0] st_wr;
   stat_rec_t [STAT_LEVELS-1:0] st_wrec;
   stat_rec_t [STAT_LEVELS-1:0] st_q;

   assign st_wr[0]   = wr_ok && (reg_sel == SEL_STAT);
   assign st_wr[1]   = wr_ok && (reg_sel == SEL_STAT);
   assign st_wr[2]   = wr_ok && (reg_sel == SEL_STAT2);
   assign st_wrec[0] = rec_from_word(reg_wdata[15:0], 0);
   assign st_wrec[1] = rec_from_word(reg_wdata[15:0], BAK_SHIFT);
   assign st_wrec[2] = rec_from_word(reg_wdata[15:0], 0);

   tss_status_stack #(.LEVELS(STAT_LEVELS)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .trap_take(trap_valid),
      .wr_lvl   (st_wr),
      .wr_rec   (st_wrec),
      .lvl_q    (st_q)
   );

   // saved PC stack
   logic [PC_DEPTH-1:0]             pc_wr;
   logic [PC_DEPTH-1:0][ADDR_W-1:0] pc_q;

   assign pc_wr[0] = wr_ok && (reg_sel == SEL_SPC);
   assign pc_wr[1] = wr_ok && (reg_sel == SEL_SPC2);

   tss_pc_stack #(
      .ADDR_W   (ADDR_W),
      .DEPTH    (PC_DEPTH),
      .RET_OFF  (RET_OFF),
      .ALIGN_LG2(2)
   ) u_pcs (
      .clk      (clk),
      .rst_n    (rst_n),
      .trap_take(trap_valid),
      .trap_pc  (trap_pc),
      .wr_lvl   (pc_wr),
      .wr_data  (reg_wdata),
      .pc_q     (pc_q)
   );

   tss_vector_gen #(
      .ADDR_W    (ADDR_W),
      .NUM_W     (NUM_W),
      .VEC_BASE  (VEC_BASE),
      .STRIDE_LG2(STRIDE_LG2)
   ) u_vec (
      .num(trap_num),
      .vec(vector_addr)
   );

   assign vector_valid = trap_valid;

   // read mux
   logic [15:0] stat_word;
   logic [15:0] stat2_word;
   assign stat_word  = word_from_rec(st_q[0], 0) | word_from_rec(st_q[1], BAK_SHIFT);
   assign stat2_word = word_from_rec(st_q[2], 0);

   always_comb begin
      unique case (reg_sel)
         SEL_STAT:  reg_rdata = ADDR_W'(stat_word);
         SEL_STAT2: reg_rdata = ADDR_W'(stat2_word);
         SEL_SPC:   reg_rdata = pc_q[0];
         default:   reg_rdata = pc_q[1];
      endcase
   end

   // R9: a trap beats a simultaneous status write, interrupt enable ends up clear
   a_r9_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && reg_wr_en && reg_sel == SEL_STAT) |=> !st_q[0].ien && !st_q[0].cnd);

   // R7: the redirect address lies on a vector slot boundary
   a_r7_vec_slot: assert property (@(posedge clk) disable iff (!rst_n)
      vector_valid |-> vector_addr[STRIDE_LG2-1:0] == '0);

   // R8: with no trap and no write, the state holds still
   a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_valid && !reg_wr_en) |=> $stable(stat_word) && $stable(stat2_word) && $stable(pc_q));

endmodule

// File: tb/test_trap_state_stack.sv
module test_trap_state_stack;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        trap_valid = 1'b0;
   logic [3:0]  trap_num = '0;
   logic [31:0] trap_pc = '0;
   logic        vector_valid;
   logic [31:0] vector_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   trap_state_stack i_trap_state_stack (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .trap_valid(trap_valid), .trap_num(trap_num), .trap_pc(trap_pc),
      .vector_valid(vector_valid), .vector_addr(vector_addr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [31:0] stat_pack(input bit bs, bi, bc, s, i, c);
      return (32'(bs) << 15) | (32'(bi) << 14) | (32'(bc) << 8) | (32'(s) << 7) | (32'(i) << 6) | 32'(c);
   endfunction

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      for (int s = 0; s < 4; s++) begin
         rd(2'(s), v);
         check("R10 reset value", v, 32'h0);
      end

      // R1, R2, R11: layout and masking on writes
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R1 status layout", v, 32'h0000_C1C1);
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); check("R2 second-backup layout", v, 32'h0000_00C1);
      wr(2'd2, 32'h1234_567B);
      rd(2'd2, v); check("R11 backup PC aligned", v, 32'h1234_5678);
      wr(2'd3, 32'h0000_0FFF);
      rd(2'd3, v); check("R11 second backup PC aligned", v, 32'h0000_0FFC);

      // R7: every trap number
      for (int n = 0; n < 16; n++) begin
         @(negedge clk);
         trap_num = 4'(n); #1;
         check("R7 vector idle valid", 32'(vector_valid), 32'h0);
         trap_valid = 1'b1; #1;
         check("R7 vector valid", 32'(vector_valid), 32'h1);
         check("R7 vector address", vector_addr, 32'h40 + 32'(n) * 4);
         trap_valid = 1'b0;
      end

      // R3..R6, R8, R9: all 64 combinations of current and backup fields
      for (int c = 0; c < 64; c++) begin
         logic [31:0] st, st2, bpc, pc, exp_st, exp_st2;
         bit bs, bi, bc, s, i, k, collide;
         bs = c[5]; bi = c[4]; bc = c[3]; s = c[2]; i = c[1]; k = c[0];
         st  = stat_pack(bs, bi, bc, s, i, k);
         st2 = (c % 3 == 0) ? 32'hC1 : 32'h40;
         bpc = 32'h0000_2000 + 32'(c) * 16;
         pc  = 32'h0001_0000 + 32'(c) * 8 + 32'(c % 4);
         collide = (c % 4 == 1);
         wr(2'd0, st | 32'h3E3E);
         wr(2'd1, st2);
         wr(2'd2, bpc);
         wr(2'd3, 32'hDEAD_BEEF);
         @(negedge clk);
         trap_valid = 1'b1; trap_num = 4'(c); trap_pc = pc;
         if (collide) begin
            reg_wr_en = 1'b1; reg_wdata = 32'hFFFF_FFFF;
         end
         rd(2'd0, v); check("R8 read in trap cycle is pre-trap", v, st);
         @(negedge clk);
         trap_valid = 1'b0; reg_wr_en = 1'b0;
         exp_st  = stat_pack(s, i, k, s, 1'b0, 1'b0);
         exp_st2 = stat_pack(1'b0, 1'b0, 1'b0, bs, bi, bc);
         rd(2'd0, v); check(collide ? "R9 write ignored, R4 status" : "R4 status after trap", v, exp_st);
         rd(2'd1, v); check("R3 second-backup after trap", v, exp_st2);
         rd(2'd2, v); check("R6 backup PC after trap", v, (pc + 32'd4) & 32'hFFFF_FFFC);
         rd(2'd3, v); check("R5 second backup PC after trap", v, bpc);
      end

      // R4: the two worked examples
      wr(2'd0, 32'h0000_00C1);
      @(negedge clk); trap_valid = 1'b1; trap_num = 4'd2; trap_pc = 32'h100;
      #1; check("R7 trap 2 vector", vector_addr, 32'h48);
      @(negedge clk); trap_valid = 1'b0;
      rd(2'd0, v); check("R4 0xC1 becomes 0xC180", v, 32'h0000_C180);
      wr(2'd0, 32'h0000_C100);
      @(negedge clk); trap_valid = 1'b1;
      @(negedge clk); trap_valid = 1'b0;
      rd(2'd0, v); check("R4 0xC100 becomes 0", v, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule